// File: doc/BRIEF.md
# Variable-Length Instruction Field Decoder

This block receives a stream of instruction bytes, one byte per cycle under a valid/ready handshake, in order of increasing address. It covers a small subset of a variable-length CISC encoding. From the first byte of each instruction it decides the instruction class and the total length, which is 1, 2 or 5 bytes. It then gathers the remaining bytes, extracts the register fields and any immediate or displacement, and emits one decoded record per instruction. Each record carries the byte offset at which the instruction began.

Six kinds of instruction are recognised: the register-to-register move, the immediate-to-register move, the add from memory into a register, the add from a register into memory, the register decrement, and five short relative jumps. A first byte outside this set, or a second byte whose mode bits do not match its opcode, gives an illegal record. Decoding then resumes on the byte that follows. The result is meant to feed a later decode or trace stage, which can use the records without knowing the byte boundaries.

Top module: `insn_stream_decoder`

## Requirements
- R1: After reset no record is offered (out_valid low), input is accepted (in_ready high), and the first instruction's offset is 0.
- R2: First byte 0x89 followed by a byte with bits [7:6]=11 gives class 0, length 2, source from bits [5:3] and destination from bits [2:0] of the second byte.
- R3: A first byte with bits [7:3]=10111 gives class 1, length 5, destination from bits [2:0], and an immediate built from the next four bytes with the first of them as the least significant byte.
- R4: First byte 0x03 with bits [7:6]=00 in the second byte gives class 2 (memory into register), with the destination in bits [5:3] and the address register (source) in bits [2:0]. First byte 0x01 with bits [7:6]=00 gives class 3 (register into memory), with the source in bits [5:3] and the address register (destination) in bits [2:0]. Both have length 2.
- R5: A first byte with bits [7:3]=01001 gives class 4, length 1, destination from bits [2:0].
- R6: First bytes 0x74, 0x75, 0x78, 0x79 and 0xEB give classes 5, 6, 7, 8 and 9, length 2, with the immediate field set to the second byte sign-extended to 32 bits.
- R7: Any other first byte gives class 15, length 1.
- R8: A second byte after 0x89 whose bits [7:6] are not 11, or after 0x03/0x01 whose bits [7:6] are not 00, gives class 15 with length 2. The following byte is decoded as the first byte of a new instruction.
- R9: Each record's offset equals the sum of the lengths of all earlier records, modulo 2^OFF_W.
- R10: While a record is offered and not taken, in_ready is low and every record field stays unchanged. No byte is lost or repeated.
- R11: Fields a class does not use read zero: the source for classes 1, 4 and 5-9; the destination for classes 5-9; the immediate for classes 0, 2, 3 and 4; and all three for class 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Next instruction byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_class | output | 4 | Instruction class code |
| out_len | output | 3 | Instruction length in bytes |
| out_src | output | 3 | Source register field |
| out_dst | output | 3 | Destination register field |
| out_imm | output | 32 | Immediate or sign-extended displacement |
| out_offset | output | OFF_W | Byte offset of the instruction's first byte |

## Verification
A directed stream comes first. It holds one known instance of each format, displacements at both sign limits, and the mode-bit violations for all three two-byte register opcodes, each followed by a byte that has to start a fresh instruction. These show whether the length is taken from the first byte, whether the immediate bytes land in the right lanes, and whether decoding resynchronises after an error. A long random mix of all kinds follows, including unknown first bytes, with random gaps on the input side and random stalls on the output side. This mix separates a correct offset accumulation and correct backpressure from designs that drop, repeat or reorder bytes when a record is held back.

// File: rtl/isd_pkg.sv
package isd_pkg;

  typedef enum logic [3:0] {
    CL_MOVRR = 4'd0,
    CL_MOVRI = 4'd1,
    CL_ADDLD = 4'd2,
    CL_ADDST = 4'd3,
    CL_DEC   = 4'd4,
    CL_JZ    = 4'd5,
    CL_JNZ   = 4'd6,
    CL_JS    = 4'd7,
    CL_JNS   = 4'd8,
    CL_JMP   = 4'd9,
    CL_BAD   = 4'd15
  } icls_e;

  localparam int IMM_W      = 32;
  localparam int IMM_BYTES  = IMM_W / 8;
  localparam logic [2:0] LEN_ONE  = 3'd1;
  localparam logic [2:0] LEN_TWO  = 3'd2;
  localparam logic [2:0] LEN_IMM  = 3'(1 + IMM_BYTES);

  function automatic logic is_jump(input logic [3:0] c);
    return (c >= 4'(CL_JZ)) && (c <= 4'(CL_JMP));
  endfunction

endpackage

// File: rtl/isd_opclass.sv
module isd_opclass
  import isd_pkg::*;
(
  input  logic [7:0] lead,
  output logic [3:0] cls,
  output logic [2:0] len,
  output logic [2:0] dst
);

  always_comb begin
    cls = 4'(CL_BAD);
    len = LEN_ONE;
    dst = 3'd0;
    if (lead[7:3] == 5'b10111) begin
      cls = 4'(CL_MOVRI);
      len = LEN_IMM;
      dst = lead[2:0];
    end else if (lead[7:3] == 5'b01001) begin
      cls = 4'(CL_DEC);
      len = LEN_ONE;
      dst = lead[2:0];
    end else begin
      case (lead)
        8'h89: begin cls = 4'(CL_MOVRR); len = LEN_TWO; end
        8'h03: begin cls = 4'(CL_ADDLD); len = LEN_TWO; end
        8'h01: begin cls = 4'(CL_ADDST); len = LEN_TWO; end
        8'h74: begin cls = 4'(CL_JZ);    len = LEN_TWO; end
        8'h75: begin cls = 4'(CL_JNZ);   len = LEN_TWO; end
        8'h78: begin cls = 4'(CL_JS);    len = LEN_TWO; end
        8'h79: begin cls = 4'(CL_JNS);   len = LEN_TWO; end
        8'hEB: begin cls = 4'(CL_JMP);   len = LEN_TWO; end
        default: begin cls = 4'(CL_BAD); len = LEN_ONE; end
      endcase
    end
  end

endmodule

// File: rtl/isd_operand.sv
module isd_operand
  import isd_pkg::*;
(
  input  logic [3:0]       cls,
  input  logic [7:0]       opnd,
  output logic [2:0]       src,
  output logic [2:0]       dst,
  output logic [IMM_W-1:0] imm,
  output logic             ok
);

  always_comb begin
    src = 3'd0;
    dst = 3'd0;
    imm = '0;
    ok  = 1'b1;
    if (cls == 4'(CL_MOVRR)) begin
      ok = (opnd[7:6] == 2'b11);
      if (ok) begin
        src = opnd[5:3];
        dst = opnd[2:0];
      end
    end else if (cls == 4'(CL_ADDLD)) begin
      ok = (opnd[7:6] == 2'b00);
      if (ok) begin
        dst = opnd[5:3];
        src = opnd[2:0];
      end
    end else if (cls == 4'(CL_ADDST)) begin
      ok = (opnd[7:6] == 2'b00);
      if (ok) begin
        src = opnd[5:3];
        dst = opnd[2:0];
      end
    end else if (is_jump(cls)) begin
      imm = {{(IMM_W-8){opnd[7]}}, opnd};
    end
  end

endmodule

// File: rtl/isd_collect.sv
module isd_collect
  import isd_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [7:0]       in_byte,
  output logic             emit,
  output logic [3:0]       r_cls,
  output logic [2:0]       r_len,
  output logic [2:0]       r_src,
  output logic [2:0]       r_dst,
  output logic [IMM_W-1:0] r_imm,
  output logic [OFF_W-1:0] r_off
);

  logic             busy_q, busy_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [3:0]       cls_q, cls_d;
  logic [2:0]       len_q, len_d;
  logic [2:0]       dst_q, dst_d;
  logic [IMM_W-1:0] imm_q, imm_d, imm_wr;
  logic [OFF_W-1:0] start_q, start_d, next_q, next_d;

  logic [3:0]       f_cls;
  logic [2:0]       f_len, f_dst;
  logic [2:0]       o_src, o_dst;
  logic [IMM_W-1:0] o_imm;
  logic             o_ok;
  logic             last;
  logic [IMM_BYTES-1:0] lane_we;

  isd_opclass u_opclass (
    .lead (in_byte),
    .cls  (f_cls),
    .len  (f_len),
    .dst  (f_dst)
  );

  isd_operand u_operand (
    .cls  (cls_q),
    .opnd (in_byte),
    .src  (o_src),
    .dst  (o_dst),
    .imm  (o_imm),
    .ok   (o_ok)
  );

  for (genvar g = 0; g < IMM_BYTES; g++) begin : g_lane
    assign lane_we[g] = take && busy_q && (cls_q == 4'(CL_MOVRI)) && (cnt_q == 3'(g + 1));
    assign imm_wr[8*g +: 8] = lane_we[g] ? in_byte : imm_q[8*g +: 8];
  end

  assign last = busy_q && (cnt_q == (len_q - 3'd1));

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    cls_d   = cls_q;
    len_d   = len_q;
    dst_d   = dst_q;
    imm_d   = imm_q;
    start_d = start_q;
    next_d  = next_q;
    emit    = 1'b0;
    r_cls   = 4'(CL_BAD);
    r_len   = LEN_ONE;
    r_src   = 3'd0;
    r_dst   = 3'd0;
    r_imm   = '0;
    r_off   = start_q;
    if (take) begin
      if (!busy_q) begin
        if (f_len == LEN_ONE) begin
          emit   = 1'b1;
          r_cls  = f_cls;
          r_len  = LEN_ONE;
          r_dst  = f_dst;
          r_off  = next_q;
          next_d = next_q + OFF_W'(1);
        end else begin
          busy_d  = 1'b1;
          cnt_d   = 3'd1;
          cls_d   = f_cls;
          len_d   = f_len;
          dst_d   = f_dst;
          imm_d   = '0;
          start_d = next_q;
        end
      end else begin
        cnt_d = cnt_q + 3'd1;
        imm_d = imm_wr;
        if (cls_q == 4'(CL_MOVRI)) begin
          if (last) begin
            emit  = 1'b1;
            r_cls = cls_q;
            r_len = LEN_IMM;
            r_dst = dst_q;
            r_imm = imm_wr;
          end
        end else begin
          emit  = 1'b1;
          r_len = LEN_TWO;
          if (o_ok) begin
            r_cls = cls_q;
            r_src = o_src;
            r_dst = o_dst;
            r_imm = o_imm;
          end
        end
        if (emit) begin
          busy_d = 1'b0;
          next_d = next_q + OFF_W'(len_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= 3'd0;
      cls_q   <= 4'(CL_BAD);
      len_q   <= LEN_ONE;
      dst_q   <= 3'd0;
      imm_q   <= '0;
      start_q <= '0;
      next_q  <= '0;
    end else if (take) begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      cls_q   <= cls_d;
      len_q   <= len_d;
      dst_q   <= dst_d;
      imm_q   <= imm_d;
      start_q <= start_d;
      next_q  <= next_d;
    end
  end

endmodule

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder
  import isd_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_class,
  output logic [2:0]       out_len,
  output logic [2:0]       out_src,
  output logic [2:0]       out_dst,
  output logic [31:0]      out_imm,
  output logic [OFF_W-1:0] out_offset
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_i_n;
  logic                   take, emit, ov_d;
  logic [3:0]             c_cls;
  logic [2:0]             c_len, c_src, c_dst;
  logic [IMM_W-1:0]       c_imm;
  logic [OFF_W-1:0]       c_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rsync_q[SYNC_STAGES-1];

  assign in_ready = rst_i_n && (!out_valid || out_ready);
  assign take     = in_valid && in_ready;

  isd_collect #(.OFF_W(OFF_W)) u_collect (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .take    (take),
    .in_byte (in_byte),
    .emit    (emit),
    .r_cls   (c_cls),
    .r_len   (c_len),
    .r_src   (c_src),
    .r_dst   (c_dst),
    .r_imm   (c_imm),
    .r_off   (c_off)
  );

  always_comb begin
    if (emit)           ov_d = 1'b1;
    else if (out_ready) ov_d = 1'b0;
    else                ov_d = out_valid;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) out_valid <= 1'b0;
    else          out_valid <= ov_d;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      out_class  <= 4'(CL_BAD);
      out_len    <= LEN_ONE;
      out_src    <= 3'd0;
      out_dst    <= 3'd0;
      out_imm    <= '0;
      out_offset <= '0;
    end else if (emit) begin
      out_class  <= c_cls;
      out_len    <= c_len;
      out_src    <= c_src;
      out_dst    <= c_dst;
      out_imm    <= c_imm;
      out_offset <= c_off;
    end
  end

endmodule

// File: rtl/isd_checker.sv
module isd_checker
  import isd_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [3:0]       out_class,
  input logic [2:0]       out_len,
  input logic [2:0]       out_src,
  input logic [2:0]       out_dst,
  input logic [31:0]      out_imm,
  input logic [OFF_W-1:0] out_offset
);

  logic [OFF_W-1:0] exp_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      exp_off <= '0;
    else if (out_valid && out_ready) exp_off <= out_offset + OFF_W'(out_len);
  end

  a_r9_offset_sum: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_offset == exp_off);

  a_r10_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class) && $stable(out_len)
      && $stable(out_src) && $stable(out_dst) && $stable(out_imm) && $stable(out_offset));

  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r2_two_byte_regs: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == 4'(CL_MOVRR) || out_class == 4'(CL_ADDLD) || out_class == 4'(CL_ADDST))
      |-> out_len == 3'd2 && out_imm == 32'd0);

  a_r3_imm_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 4'(CL_MOVRI) |-> out_len == 3'd5 && out_src == 3'd0);

  a_r5_dec_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 4'(CL_DEC) |-> out_len == 3'd1 && out_src == 3'd0 && out_imm == 32'd0);

  a_r6_jump_sext: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_jump(out_class) |-> out_len == 3'd2 && out_src == 3'd0 && out_dst == 3'd0
      && out_imm[31:8] == {24{out_imm[7]}});

  a_r11_bad_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == 4'(CL_BAD) |-> (out_len == 3'd1 || out_len == 3'd2)
      && out_src == 3'd0 && out_dst == 3'd0 && out_imm == 32'd0);

endmodule

bind insn_stream_decoder isd_checker #(.OFF_W(OFF_W)) u_isd_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_class  (out_class),
  .out_len    (out_len),
  .out_src    (out_src),
  .out_dst    (out_dst),
  .out_imm    (out_imm),
  .out_offset (out_offset)
);

// File: tb/insn_stream_decoder_test.sv
module insn_stream_decoder_test;

  localparam int OFF_W = 16;
  localparam int LIMIT = 100000;
  localparam int NRAND = 600;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid, out_ready;
  logic [7:0]       in_byte;
  logic             in_ready, out_valid;
  logic [3:0]       out_class;
  logic [2:0]       out_len, out_src, out_dst;
  logic [31:0]      out_imm;
  logic [OFF_W-1:0] out_offset;

  always #4 clk = ~clk;

  insn_stream_decoder #(.OFF_W(OFF_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_len(out_len),
    .out_src(out_src), .out_dst(out_dst), .out_imm(out_imm), .out_offset(out_offset)
  );

  logic [7:0]  bq[$];
  logic [60:0] eq[$];
  logic [OFF_W-1:0] off_acc = '0;
  int checks = 0, errors = 0, cyc = 0;
  int unsigned bi = 0, ei = 0;
  bit run = 0, held = 0;
  logic [60:0] held_rec;

  function automatic logic [60:0] pack(input logic [3:0] c, input logic [2:0] l,
      input logic [2:0] s, input logic [2:0] d, input logic [31:0] i, input logic [OFF_W-1:0] o);
    return {c, l, s, d, i, o};
  endfunction

  function automatic string tag(input logic [60:0] r);
    logic [3:0] c = r[60:57];
    if (c == 0) return "R2/R11";
    if (c == 1) return "R3/R11";
    if (c == 2 || c == 3) return "R4/R11";
    if (c == 4) return "R5/R11";
    if (c >= 5 && c <= 9) return "R6/R11";
    if (r[56:54] == 3'd1) return "R7/R11";
    return "R8/R11";
  endfunction

  function automatic bit is_opc(input logic [7:0] b);
    return (b == 8'h89) || (b == 8'h03) || (b == 8'h01) || (b == 8'h74) || (b == 8'h75) ||
           (b == 8'h78) || (b == 8'h79) || (b == 8'hEB) ||
           (b[7:3] == 5'b10111) || (b[7:3] == 5'b01001);
  endfunction

  task automatic expect_rec(input logic [3:0] c, input logic [2:0] l, input logic [2:0] s,
      input logic [2:0] d, input logic [31:0] i);
    eq.push_back(pack(c, l, s, d, i, off_acc));
    off_acc = off_acc + OFF_W'(l);
  endtask

  task automatic i_movrr(input logic [2:0] s, input logic [2:0] d);
    bq.push_back(8'h89); bq.push_back({2'b11, s, d}); expect_rec(4'd0, 3'd2, s, d, 32'd0);
  endtask
  task automatic i_movri(input logic [2:0] d, input logic [31:0] v);
    bq.push_back({5'b10111, d});
    for (int k = 0; k < 4; k++) bq.push_back(v[8*k +: 8]);
    expect_rec(4'd1, 3'd5, 3'd0, d, v);
  endtask
  task automatic i_addld(input logic [2:0] d, input logic [2:0] s);
    bq.push_back(8'h03); bq.push_back({2'b00, d, s}); expect_rec(4'd2, 3'd2, s, d, 32'd0);
  endtask
  task automatic i_addst(input logic [2:0] s, input logic [2:0] d);
    bq.push_back(8'h01); bq.push_back({2'b00, s, d}); expect_rec(4'd3, 3'd2, s, d, 32'd0);
  endtask
  task automatic i_dec(input logic [2:0] d);
    bq.push_back({5'b01001, d}); expect_rec(4'd4, 3'd1, 3'd0, d, 32'd0);
  endtask
  task automatic i_jmp(input int sel, input logic [7:0] disp);
    logic [7:0] op;
    case (sel)
      0: op = 8'h74; 1: op = 8'h75; 2: op = 8'h78; 3: op = 8'h79; default: op = 8'hEB;
    endcase
    bq.push_back(op); bq.push_back(disp);
    expect_rec(4'(5 + sel), 3'd2, 3'd0, 3'd0, {{24{disp[7]}}, disp});
  endtask
  task automatic i_bad1(input logic [7:0] b);
    bq.push_back(b); expect_rec(4'd15, 3'd1, 3'd0, 3'd0, 32'd0);
  endtask
  task automatic i_bad2(input logic [7:0] op, input logic [7:0] b1);
    bq.push_back(op); bq.push_back(b1); expect_rec(4'd15, 3'd2, 3'd0, 3'd0, 32'd0);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      cyc++;
      if (bi < bq.size() && ($urandom % 5) != 0) begin
        in_valid = 1'b1; in_byte = bq[bi];
      end else begin
        in_valid = 1'b0; in_byte = $urandom;
      end
      out_ready = (bi < 40) ? 1'b1 : (($urandom % 3) != 0);
      #1;
      if (held)
        check(out_valid && pack(out_class, out_len, out_src, out_dst, out_imm, out_offset) == held_rec,
              "R10 hold", 64'(pack(out_class, out_len, out_src, out_dst, out_imm, out_offset)), 64'(held_rec));
      if (out_valid && !out_ready)
        check(!in_ready, "R10 in_ready", 64'(in_ready), 64'd0);
      held = out_valid && !out_ready;
      held_rec = pack(out_class, out_len, out_src, out_dst, out_imm, out_offset);
      if (out_valid && out_ready) begin
        if (ei < eq.size()) begin
          check(held_rec[60:16] == eq[ei][60:16], tag(eq[ei]), 64'(held_rec[60:16]), 64'(eq[ei][60:16]));
          check(out_offset == eq[ei][15:0], (ei == 0) ? "R1 R9 offset" : "R9 offset",
                64'(out_offset), 64'(eq[ei][15:0]));
          ei++;
        end else begin
          check(1'b0, "R10 extra record", 64'(held_rec), 64'd0);
        end
      end
      if (in_valid && in_ready) bi++;
    end
  end

  initial begin
    logic [7:0] b;
    int k, t;
    void'($urandom(32'd2718));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
    // directed stream
    i_movrr(3'd0, 3'd3);
    i_movri(3'd0, 32'd4);
    i_movri(3'd7, 32'hA1B2C3D4);
    i_addld(3'd3, 3'd1);
    i_addst(3'd1, 3'd3);
    i_dec(3'd0);
    i_jmp(1, 8'hF8);
    i_jmp(0, 8'h7F);
    i_jmp(2, 8'h80);
    i_jmp(3, 8'h00);
    i_jmp(4, 8'hFF);
    i_bad1(8'h90);
    i_bad2(8'h89, 8'h05);
    i_dec(3'd3);
    i_bad2(8'h03, 8'hC1);
    i_movrr(3'd2, 3'd1);
    i_bad2(8'h01, 8'h40);
    i_bad1(8'hFF);
    // random mix
    for (int n = 0; n < NRAND; n++) begin
      k = $urandom % 9;
      case (k)
        0: i_movrr(3'($urandom), 3'($urandom));
        1: i_movri(3'($urandom), $urandom);
        2: i_addld(3'($urandom), 3'($urandom));
        3: i_addst(3'($urandom), 3'($urandom));
        4: i_dec(3'($urandom));
        5: i_jmp($urandom % 5, 8'($urandom));
        6: begin
          b = 8'($urandom);
          while (is_opc(b)) b = 8'($urandom);
          i_bad1(b);
        end
        7: begin
          t = $urandom % 3;
          b = 8'($urandom);
          if (t == 0) i_bad2(8'h89, {2'($urandom % 3), b[5:0]});
          else        i_bad2((t == 1) ? 8'h03 : 8'h01, {2'(1 + $urandom % 3), b[5:0]});
        end
        default: i_movrr(3'($urandom), 3'($urandom));
      endcase
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    run = 1'b1;
    while (!(ei == eq.size() && bi == bq.size()) && cyc < LIMIT) @(posedge clk);
    if (cyc >= LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d records", ei, eq.size());
    end
    repeat (4) @(posedge clk);
    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule